// File: doc/BRIEF.md
# Two-parallel fast FIR filter

This block is a fixed-coefficient FIR filter that runs at twice the sample rate of its clock. Each cycle with `in_valid` high, it takes one block of two consecutive samples from an interleaved stream: the even-phase sample `in_x0` (earlier in time) and the odd-phase sample `in_x1` (later). Two cycles later it returns the matching two filtered samples. The filter taps `TAPS[0..NTAPS-1]` are parameters. The tap set must be mirror-symmetric, with `TAPS[i] == TAPS[NTAPS-1-i]`, and `NTAPS` must be a multiple of four.

Internally, the even taps H0 and the odd taps H1 form three half-length sub-filters instead of four. The first runs on X0+X1 with taps H0+H1. The second runs on X0−X1 with taps H0−H1. The third runs on X1 with taps H1. When the full tap set is symmetric, the H0+H1 set is symmetric and the H0−H1 set is antisymmetric. Those two sub-filters therefore add or subtract each pair of mirrored delay-line samples before a single multiply, so one multiplier serves two taps. A post stage combines the three results:

- odd output = (A−B)/2
- even output = (A+B)/2 − C + C of the previous block

The halving is exact. Each output is then rounded and saturated to the data width.

The filter runs as a straight three-register pipeline: delay lines, then sub-filter accumulators, then output registers. There is no state machine. Cycles with `in_valid` low freeze the history.

Top module: `fir2_fast`

## Requirements
- R1: For the interleaved stream x[0], x[1], … formed as in_x0 then in_x1 of each accepted block, block m gives out_y0 = y[2m] and out_y1 = y[2m+1], where y[n] is computed from the full-precision sum of TAPS[i]·x[n−i] over i = 0..NTAPS−1.
- R2: Each output is the full-precision sum with 2^(FRAC−1) added, then shifted right arithmetically by FRAC bits (round half toward +infinity). FRAC defaults to 15.
- R3: An output whose rounded value lies outside −32768..32767 comes out as −32768 or 32767, whichever is nearer.
- R4: A block sampled with in_valid high at clock edge k shows on out_y0/out_y1 with out_valid high right after edge k+2. out_valid is low in every other cycle.
- R5: A cycle with in_valid low does not advance the history. out_y0 and out_y1 keep their previous values while out_valid is low.
- R6: After reset, the filter behaves as though every sample before the first accepted block were zero.
- R7: While rst (synchronous, active high) is held, out_valid, out_y0 and out_y1 read 0.
- R8: The sum and the difference of the two folded sub-filter results are always even, so the halving discards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A two-sample block is present this cycle |
| in_x0 | input | 16 | Even-phase sample (earlier), signed |
| in_x1 | input | 16 | Odd-phase sample (later), signed |
| out_valid | output | 1 | Output block valid |
| out_y0 | output | 16 | Even-phase filtered sample, signed |
| out_y1 | output | 16 | Odd-phase filtered sample, signed |

## Verification
A gap in the input can land in the same cycle that an earlier block is still moving through the sub-filter and post stages. So the history freeze and the delivery of a result overlap. The bench provokes this by dropping `in_valid` for one or more cycles straight after accepted blocks. It then checks that the in-flight results still arrive on time and with the right values. It also checks that the outputs hold during the idle cycles, and that the next block continues the convolution as if the gap had not happened. A second overlap comes from asserting reset while blocks are in flight. That case is judged by all-zero outputs during reset and by zero-history results afterwards.

// File: rtl/fir2_pkg.sv
package fir2_pkg;
    // Kind of folded sub-filter: mirrored samples are added or subtracted
    typedef enum logic {
        FOLD_SUM  = 1'b0,
        FOLD_DIFF = 1'b1
    } fold_e;
endpackage

// File: rtl/fir2_fold_sub.sv
// Half-length sub-filter on a pre-added stream whose taps are
// TAPS[2k] +/- TAPS[2k+1]. Symmetric (SUM) or antisymmetric (DIFF)
// taps let one multiplier serve each mirrored pair.
module fir2_fold_sub
    import fir2_pkg::*;
#(
    parameter int    IW    = 17,
    parameter int    CW    = 16,
    parameter int    NTAPS = 24,
    parameter int    ACC_W = 41,
    parameter fold_e KIND  = FOLD_SUM,
    parameter logic signed [CW-1:0] TAPS [NTAPS] = '{default: '0}
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  logic                    load_en,
    input  logic signed [IW-1:0]    din,
    output logic signed [ACC_W-1:0] acc
);
    localparam int M = NTAPS / 2;
    localparam int P = M / 2;

    logic signed [IW-1:0]    tap_q [M];
    logic signed [ACC_W-1:0] prod  [P];
    logic signed [ACC_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < M; i++) tap_q[i] <= '0;
        end else if (shift_en) begin
            tap_q[0] <= din;
            for (int i = 1; i < M; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    for (genvar k = 0; k < P; k++) begin : g_pair
        localparam int CK = (KIND == FOLD_SUM)
                          ? int'(TAPS[2*k]) + int'(TAPS[2*k+1])
                          : int'(TAPS[2*k]) - int'(TAPS[2*k+1]);
        logic signed [IW:0] pre;
        always_comb begin
            if (KIND == FOLD_SUM)
                pre = (IW+1)'(tap_q[k]) + (IW+1)'(tap_q[M-1-k]);
            else
                pre = (IW+1)'(tap_q[k]) - (IW+1)'(tap_q[M-1-k]);
        end
        assign prod[k] = ACC_W'(pre) * ACC_W'(CK);
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < P; k++) sum = sum + prod[k];
    end

    always_ff @(posedge clk) begin
        if (rst)          acc <= '0;
        else if (load_en) acc <= sum;
    end
endmodule

// File: rtl/fir2_plain_sub.sv
// Half-length sub-filter on the odd phase with the odd taps TAPS[2k+1].
module fir2_plain_sub #(
    parameter int IW    = 16,
    parameter int CW    = 16,
    parameter int NTAPS = 24,
    parameter int ACC_W = 41,
    parameter logic signed [CW-1:0] TAPS [NTAPS] = '{default: '0}
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  logic                    load_en,
    input  logic signed [IW-1:0]    din,
    output logic signed [ACC_W-1:0] acc
);
    localparam int M = NTAPS / 2;

    logic signed [IW-1:0]    tap_q [M];
    logic signed [ACC_W-1:0] prod  [M];
    logic signed [ACC_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < M; i++) tap_q[i] <= '0;
        end else if (shift_en) begin
            tap_q[0] <= din;
            for (int i = 1; i < M; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    for (genvar k = 0; k < M; k++) begin : g_tap
        localparam int CK = int'(TAPS[2*k+1]);
        assign prod[k] = ACC_W'(tap_q[k]) * ACC_W'(CK);
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < M; k++) sum = sum + prod[k];
    end

    always_ff @(posedge clk) begin
        if (rst)          acc <= '0;
        else if (load_en) acc <= sum;
    end
endmodule

// File: rtl/fir2_post.sv
// Post-adders: exact halving, the one-block-delayed odd-tap term,
// rounding and saturation.
module fir2_post #(
    parameter int DW    = 16,
    parameter int FRAC  = 15,
    parameter int ACC_W = 41
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_en,
    input  logic signed [ACC_W-1:0] sub_a,
    input  logic signed [ACC_W-1:0] sub_b,
    input  logic signed [ACC_W-1:0] sub_c,
    output logic signed [DW-1:0]    y0,
    output logic signed [DW-1:0]    y1
);
    localparam int SW = ACC_W + 2;
    localparam logic signed [SW-1:0] HALF = {{(SW-1){1'b0}}, 1'b1} << (FRAC - 1);
    localparam logic signed [SW-1:0] MAXV = SW'((1 << (DW - 1)) - 1);
    localparam logic signed [SW-1:0] MINV = SW'(-(1 << (DW - 1)));

    logic signed [SW-1:0]    s_ab, d_ab, full0, full1;
    logic signed [ACC_W-1:0] c_prev;

    function automatic logic signed [DW-1:0] round_sat(input logic signed [SW-1:0] v);
        logic signed [SW-1:0] r;
        r = (v + HALF) >>> FRAC;
        if (r > MAXV)      return MAXV[DW-1:0];
        else if (r < MINV) return MINV[DW-1:0];
        else               return r[DW-1:0];
    endfunction

    always_comb begin
        s_ab  = SW'(sub_a) + SW'(sub_b);
        d_ab  = SW'(sub_a) - SW'(sub_b);
        full0 = (s_ab >>> 1) - SW'(sub_c) + SW'(c_prev);
        full1 = d_ab >>> 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_prev <= '0;
            y0     <= '0;
            y1     <= '0;
        end else if (load_en) begin
            c_prev <= sub_c;
            y0     <= round_sat(full0);
            y1     <= round_sat(full1);
        end
    end

    // R8: the sum and the difference of the two folded results are even
    p_even_halving_r8: assert property (@(posedge clk) disable iff (rst)
        load_en |-> (!s_ab[0] && !d_ab[0]));

    // R5: outputs hold when no block is being delivered
    p_hold_outputs_r5: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ($stable(y0) && $stable(y1)));
endmodule

// File: rtl/fir2_fast.sv
module fir2_fast
    import fir2_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int NTAPS = 24,
    parameter int FRAC  = 15,
    parameter logic signed [CW-1:0] TAPS [NTAPS] = '{
        16'sd120,   -16'sd340,  16'sd610,   -16'sd900,
        16'sd1300,  -16'sd1800, 16'sd2500,  -16'sd3400,
        16'sd4600,  -16'sd6200, 16'sd9000,  16'sd16000,
        16'sd16000, 16'sd9000,  -16'sd6200, 16'sd4600,
        -16'sd3400, 16'sd2500,  -16'sd1800, 16'sd1300,
        -16'sd900,  16'sd610,   -16'sd340,  16'sd120}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_x0,
    input  logic signed [DW-1:0] in_x1,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_y0,
    output logic signed [DW-1:0] out_y1
);
    localparam int ACC_W = DW + CW + 4 + $clog2(NTAPS);

    logic signed [DW:0]      pre_sum, pre_dif;
    logic signed [ACC_W-1:0] acc_a, acc_b, acc_c;
    logic                    v1, v2;

    always_comb begin
        pre_sum = (DW+1)'(in_x0) + (DW+1)'(in_x1);
        pre_dif = (DW+1)'(in_x0) - (DW+1)'(in_x1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1        <= in_valid;
            v2        <= v1;
            out_valid <= v2;
        end
    end

    fir2_fold_sub #(.IW(DW+1), .CW(CW), .NTAPS(NTAPS), .ACC_W(ACC_W),
                    .KIND(FOLD_SUM), .TAPS(TAPS)) u_sub_a (
        .clk(clk), .rst(rst), .shift_en(in_valid), .load_en(v1),
        .din(pre_sum), .acc(acc_a));

    fir2_fold_sub #(.IW(DW+1), .CW(CW), .NTAPS(NTAPS), .ACC_W(ACC_W),
                    .KIND(FOLD_DIFF), .TAPS(TAPS)) u_sub_b (
        .clk(clk), .rst(rst), .shift_en(in_valid), .load_en(v1),
        .din(pre_dif), .acc(acc_b));

    fir2_plain_sub #(.IW(DW), .CW(CW), .NTAPS(NTAPS), .ACC_W(ACC_W),
                     .TAPS(TAPS)) u_sub_c (
        .clk(clk), .rst(rst), .shift_en(in_valid), .load_en(v1),
        .din(in_x1), .acc(acc_c));

    fir2_post #(.DW(DW), .FRAC(FRAC), .ACC_W(ACC_W)) u_post (
        .clk(clk), .rst(rst), .load_en(v2),
        .sub_a(acc_a), .sub_b(acc_b), .sub_c(acc_c),
        .y0(out_y0), .y1(out_y1));

    // R4: every accepted block reaches the output after a fixed delay
    p_latency_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    // R4: no output without a block accepted at the matching edge
    p_latency_back_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));
endmodule

// File: tb/sim_fir2_fast.sv
`timescale 1ns/1ps
module sim_fir2_fast;
    localparam int NT   = 24;
    localparam int FR   = 15;
    localparam int HMAX = 4096;

    localparam int H [NT] = '{120, -340, 610, -900, 1300, -1800, 2500, -3400,
                              4600, -6200, 9000, 16000, 16000, 9000, -6200, 4600,
                              -3400, 2500, -1800, 1300, -900, 610, -340, 120};

    // stimulus table: {x0, x1}
    localparam int NV = 20;
    localparam logic [31:0] VEC [NV] = '{
        {16'sd1000, 16'sd0},      {16'sd0, 16'sd0},         {-16'sd500, 16'sd250},
        {16'sd32767, -16'sd32768},{16'sd12, -16'sd7},       {16'sd4000, 16'sd4000},
        {-16'sd4000, -16'sd4000}, {16'sd1, 16'sd1},         {16'sd20000, -16'sd15000},
        {-16'sd1234, 16'sd5678},  {16'sd0, 16'sd32767},     {16'sd100, -16'sd100},
        {-16'sd32768, 16'sd0},    {16'sd777, 16'sd888},     {16'sd3, -16'sd3},
        {16'sd15000, 16'sd15000}, {-16'sd9999, 16'sd1111},  {16'sd42, 16'sd0},
        {16'sd0, -16'sd42},       {16'sd2500, -16'sd2500}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_x0 = '0, in_x1 = '0;
    logic out_valid;
    logic signed [15:0] out_y0, out_y1;

    fir2_fast u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_x0(in_x0),
                  .in_x1(in_x1), .out_valid(out_valid), .out_y0(out_y0),
                  .out_y1(out_y1));

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    longint hist [HMAX];
    int nx = 0;
    int e_y0 [HMAX], e_y1 [HMAX], e_due [HMAX], e_tag0 [HMAX];
    int head = 0, tail = 0;
    logic signed [15:0] last0 = '0, last1 = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    function automatic int ref_out(input int n, output bit sat);
        longint acc = 0;
        longint r;
        for (int i = 0; i < NT; i++)
            if (n - i >= 0) acc += longint'(H[i]) * hist[n-i];
        r = (acc + (longint'(1) <<< (FR - 1))) >>> FR;
        sat = (r > 32767) || (r < -32768);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic fail_line(input string req, input int got, input int exp);
        n_bad++;
        $display("FAIL %s got %0d expected %0d at cycle %0d", req, got, exp, cyc);
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic cmp_y(input int got, input int exp, input int tag);
        n_chk++;
        if (got != exp) begin
            if (tag == 3)      fail_line("R3 saturation", got, exp);
            else if (tag == 6) fail_line("R6 zero history", got, exp);
            else               fail_line("R1 R2 value", got, exp);
        end
    endtask

    task automatic check_out;
        bit ev = (head < tail) && (e_due[head] == cyc);
        n_chk++;
        if (out_valid !== ev) fail_line("R4 out_valid", int'(out_valid), int'(ev));
        if (ev) begin
            cmp_y(int'(out_y0), e_y0[head], e_tag0[head] & 15);
            cmp_y(int'(out_y1), e_y1[head], e_tag0[head] >> 4);
            head++;
        end else begin
            n_chk++;
            if (out_y0 !== last0 || out_y1 !== last1)
                fail_line("R5 hold", int'(out_y0), int'(last0));
        end
        last0 = out_y0;
        last1 = out_y1;
    endtask

    task automatic step(input bit v, input logic signed [15:0] a,
                        input logic signed [15:0] b);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_x0 = a;
        in_x1 = b;
        if (v) begin
            bit s0, s1;
            int t0, t1;
            hist[nx] = longint'(a);
            hist[nx+1] = longint'(b);
            nx += 2;
            e_y0[tail] = ref_out(nx - 2, s0);
            e_y1[tail] = ref_out(nx - 1, s1);
            t0 = s0 ? 3 : ((nx <= NT) ? 6 : 1);
            t1 = s1 ? 3 : ((nx <= NT) ? 6 : 1);
            e_tag0[tail] = t0 | (t1 << 4);
            e_due[tail] = cyc + 3;
            tail++;
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1;
        in_valid = 0;
        @(negedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0) fail_line("R7 reset valid", int'(out_valid), 0);
        n_chk++;
        if (out_y0 !== 16'sd0 || out_y1 !== 16'sd0)
            fail_line("R7 reset outputs", int'(out_y0), 0);
        rst = 0;
        nx = 0;
        head = 0;
        tail = 0;
        last0 = '0;
        last1 = '0;
    endtask

    task automatic flush;
        for (int i = 0; i < 5; i++) step(0, '0, '0);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t = s;
        t ^= t << 13;
        t ^= t >> 17;
        t ^= t << 5;
        return t;
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        report();
    end

    initial begin
        // R7: reset state
        do_reset();
        // R1 R2 R6: table of stimulus vectors
        for (int i = 0; i < NV; i++)
            step(1, VEC[i][31:16], VEC[i][15:0]);
        flush();
        // R5: gaps while earlier blocks are in flight
        for (int i = 0; i < 16; i++) begin
            step(1, 16'(i * 1500 - 9000), 16'(7000 - i * 900));
            if (i % 3 == 0) step(0, 16'sh5555, -16'sh2222);
            if (i % 5 == 1) begin
                step(0, '0, '0);
                step(0, 16'sh7fff, 16'sh7fff);
            end
        end
        flush();
        // R6: impulse after reset gives the rounded taps
        do_reset();
        step(1, 16'sd32767, 16'sd0);
        for (int i = 0; i < 13; i++) step(1, '0, '0);
        flush();
        // R3: full-scale inputs matched to tap signs, then DC extremes
        for (int i = 0; i < 14; i++) begin
            logic signed [15:0] a = (H[(2 * i) % NT] > 0) ? 16'sd32767 : -16'sd32768;
            step(1, a, -a);
        end
        for (int i = 0; i < 14; i++) step(1, 16'sd32767, 16'sd32767);
        for (int i = 0; i < 14; i++) step(1, -16'sd32768, -16'sd32768);
        // reset with blocks in flight, then fresh history
        do_reset();
        for (int i = 0; i < 8; i++) step(1, 16'(300 * i), -16'(200 * i));
        flush();
        // pseudo-random stream with random gaps
        for (int i = 0; i < 300; i++) begin
            lfsr = nxt(lfsr);
            step(lfsr[31:29] != 3'b000, lfsr[15:0], lfsr[28:13]);
        end
        flush();
        report();
    end
endmodule